// File: doc/BRIEF.md
# Thermal Alarm Comparator with Fault Queue

This block watches a stream of temperature conversion results. It drives one alarm line from them. Each result arrives with a valid strobe and is compared, as a signed value, against a programmable upper set-point and a lower release threshold. A result above the set-point counts as "hot" and one below the release threshold counts as "cold". A result between the two is neutral.

A fault queue debounces the alarm: it may change only after a programmed number of consecutive results that agree on the same side.

The alarm runs in one of two modes:

- **Thermostat mode:** the alarm follows the temperature with hysteresis.
- **Latched mode:** once raised, the alarm stays up until the surrounding logic signals that any register was read.

A shutdown input stops the evaluation of samples. Entering shutdown clears a latched alarm and leaves a thermostat alarm where it was. The alarm pin is open-drain, so it is modelled as a pull-low enable. A polarity setting decides whether the asserted alarm drives the line low or releases it high.

Top module: `thermal_alarm`

## Requirements
- R1: After reset the alarm is inactive and the consecutive-sample counter is zero.
- R2: Temperature, set-point and release threshold are 9-bit two's-complement values. A sample is hot when temperature > set-point and cold when temperature < release threshold, both compared signed. If both conditions hold, hot wins. A sample equal to either limit does not meet that condition.
- R3: `queue_sel` gives the number of consecutive agreeing samples needed before the alarm may change: 00 = 1, 01 = 2, 10 = 4, 11 = 6.
- R4: A neutral sample clears the consecutive count. A sample on the opposite side from the previous one restarts the count at one.
- R5: Thermostat mode (`latch_mode` = 0): a qualified hot run raises the alarm and a qualified cold run lowers it, each visible one cycle after the deciding sample.
- R6: Latched mode (`latch_mode` = 1): a raised alarm stays up through cold samples. A `reg_read` pulse clears it on the next cycle.
- R7: In latched mode `reg_read` also clears the count and takes priority over a sample in the same cycle. The alarm rises again only after a fresh qualified hot run on later samples.
- R8: In thermostat mode `reg_read` has no effect.
- R9: While `shutdown` is high, samples are ignored. The first cycle of shutdown clears the count, clears the alarm in latched mode, and leaves the alarm unchanged in thermostat mode.
- R10: `alarm_pull_low` is 1 exactly when the line must be low. With `alarm_pol` = 1 (active-high) that is when the alarm is inactive. With `alarm_pol` = 0 (active-low) that is when the alarm is active.
- R11: Cycles with `smp_valid` low change neither the alarm nor the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | New conversion result present |
| smp_temp | input | 9 | Signed conversion result, half-degree steps |
| set_point | input | 9 | Signed upper (trip) threshold |
| hyst_lim | input | 9 | Signed lower (release) threshold |
| latch_mode | input | 1 | 0 = thermostat, 1 = latched |
| alarm_pol | input | 1 | 1 = active-high line, 0 = active-low line |
| queue_sel | input | 2 | Consecutive-sample depth code |
| shutdown | input | 1 | Halt evaluation of samples |
| reg_read | input | 1 | One-cycle pulse: a register was read |
| alarm_on | output | 1 | Logical alarm state |
| alarm_pull_low | output | 1 | Open-drain enable; 1 pulls the line low |

## Verification
The bench sweeps every 9-bit temperature against fixed limits. That exposes an unsigned comparison, which would call negative readings hot, and an inclusive comparison, which would trip on a reading equal to a limit.

For each queue depth and mode it feeds runs of hot and cold samples broken by neutral and opposite-side samples. An off-by-one in the depth decode, or a counter that does not restart, would move the alarm edge by a sample.

Read pulses arrive together with hot samples and during thermostat mode. Shutdown is entered with the alarm both raised and lowered. A design that let a same-cycle sample win over the read, or that cleared a thermostat alarm on shutdown, shows a wrong alarm level in the following cycle.

// File: rtl/thermal_alarm.sv
module thermal_alarm #(
  parameter int TW   = 9,
  parameter int QMAX = 6,
  localparam int CW  = $clog2(QMAX + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_valid,
  input  logic signed [TW-1:0] smp_temp,
  input  logic signed [TW-1:0] set_point,
  input  logic signed [TW-1:0] hyst_lim,
  input  logic                 latch_mode,
  input  logic                 alarm_pol,
  input  logic [1:0]           queue_sel,
  input  logic                 shutdown,
  input  logic                 reg_read,
  output logic                 alarm_on,
  output logic                 alarm_pull_low
);

  logic          alarm, side, sd_q, hot, cold, take, sd_entry, clr_lat, qual;
  logic [CW-1:0] cnt, cnt_inc, need;

  assign hot      = smp_temp > set_point;
  assign cold     = smp_temp < hyst_lim;
  assign take     = smp_valid && !shutdown;
  assign sd_entry = shutdown && !sd_q;
  assign clr_lat  = latch_mode && reg_read;

  always_comb begin
    case (queue_sel)
      2'd0:    need = CW'(1);
      2'd1:    need = CW'(2);
      2'd2:    need = CW'(4);
      default: need = CW'(QMAX);
    endcase
    if (cnt != '0 && side == hot)
      cnt_inc = (cnt >= CW'(QMAX)) ? CW'(QMAX) : cnt + CW'(1);
    else
      cnt_inc = CW'(1);
  end

  assign qual = cnt_inc >= need;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm <= 1'b0;
      side  <= 1'b0;
      sd_q  <= 1'b0;
      cnt   <= '0;
    end else begin
      sd_q <= shutdown;
      if (sd_entry) begin
        cnt <= '0;
        if (latch_mode) alarm <= 1'b0;
      end else if (clr_lat) begin
        cnt   <= '0;
        alarm <= 1'b0;
      end else if (take) begin
        if (!hot && !cold) begin
          cnt <= '0;
        end else begin
          cnt  <= cnt_inc;
          side <= hot;
          if (qual) begin
            if (hot) alarm <= 1'b1;
            else if (!latch_mode) alarm <= 1'b0;
          end
        end
      end
    end
  end

  assign alarm_on       = alarm;
  assign alarm_pull_low = alarm_pol ? !alarm : alarm;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(QMAX)); // R3
  AST_IDLE_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> !$rose(alarm_on)); // R11
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_mode && alarm_on && !reg_read && !shutdown) |=> alarm_on); // R6
  AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_mode && reg_read) |=> !alarm_on); // R7
  AST_SD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (shutdown && !latch_mode) |=> $stable(alarm_on)); // R9
  AST_SD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (shutdown && latch_mode && !sd_q) |=> !alarm_on); // R9

endmodule

// File: tb/thermal_alarm_tb.sv
module thermal_alarm_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic smp_valid = 1'b0, latch_mode = 1'b0, alarm_pol = 1'b1;
  logic shutdown = 1'b0, reg_read = 1'b0;
  logic signed [8:0] smp_temp = '0, set_point = 9'sd40, hyst_lim = 9'sd20;
  logic [1:0] queue_sel = 2'd0;
  logic alarm_on, alarm_pull_low;

  int errors = 0, checks = 0;
  logic m_alarm, m_side, m_sdq;
  int m_cnt;

  always #2 clk = ~clk;

  thermal_alarm u_dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_temp(smp_temp),
    .set_point(set_point), .hyst_lim(hyst_lim), .latch_mode(latch_mode),
    .alarm_pol(alarm_pol), .queue_sel(queue_sel), .shutdown(shutdown),
    .reg_read(reg_read), .alarm_on(alarm_on), .alarm_pull_low(alarm_pull_low)
  );

  function automatic int depth(input logic [1:0] q);
    return (q == 2'd0) ? 1 : (q == 2'd1) ? 2 : (q == 2'd2) ? 4 : 6;
  endfunction

  task automatic check(input string tag);
    logic exp_pl;
    exp_pl = alarm_pol ? !m_alarm : m_alarm;
    checks++;
    if (alarm_on !== m_alarm || alarm_pull_low !== exp_pl) begin
      errors++;
      $display("FAIL %s: alarm_on=%b pull_low=%b expected %b %b (temp=%0d q=%0d mode=%b)",
               tag, alarm_on, alarm_pull_low, m_alarm, exp_pl, smp_temp, queue_sel, latch_mode);
    end
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst_n = 1'b0; smp_valid = 0; reg_read = 0; shutdown = 0;
    m_alarm = 0; m_side = 0; m_sdq = 0; m_cnt = 0;
    @(negedge clk);
    check(tag);
    rst_n = 1'b1;
  endtask

  task automatic step(input logic v, input int t, input logic rd, input logic sd, input string tag);
    logic h, c;
    int n;
    @(negedge clk);
    smp_valid = v; smp_temp = 9'(t); reg_read = rd; shutdown = sd;
    @(posedge clk);
    h = smp_temp > set_point;
    c = smp_temp < hyst_lim;
    if (sd && !m_sdq) begin
      m_cnt = 0;
      if (latch_mode) m_alarm = 0;
    end else if (latch_mode && rd) begin
      m_cnt = 0; m_alarm = 0;
    end else if (v && !sd) begin
      if (!h && !c) m_cnt = 0;
      else begin
        n = (m_cnt != 0 && m_side == h) ? ((m_cnt >= 6) ? 6 : m_cnt + 1) : 1;
        m_cnt = n; m_side = h;
        if (n >= depth(queue_sel)) begin
          if (h) m_alarm = 1;
          else if (!latch_mode) m_alarm = 0;
        end
      end
    end
    m_sdq = sd;
    #1;
    check(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset("R1");
    alarm_pol = 1'b0;
    do_reset("R10");
    alarm_pol = 1'b1;

    // R2: exhaustive signed sweep, both directions, depth 1
    for (int t = -256; t < 256; t++) step(1, t, 0, 0, "R2");
    for (int t = 255; t >= -256; t--) step(1, t, 0, 0, "R2");
    for (int t = 18; t <= 42; t++) step(1, t, 0, 0, "R2_boundary");

    for (int mode = 0; mode < 2; mode++) begin
      for (int q = 0; q < 4; q++) begin
        for (int pol = 0; pol < 2; pol++) begin
          latch_mode = 1'(mode); queue_sel = 2'(q); alarm_pol = 1'(pol);
          do_reset("R1");
          for (int k = 0; k < 7; k++) step(1, 60, 0, 0, "R3");
          step(0, -100, 0, 0, "R11");
          step(0, 100, 0, 0, "R11");
          for (int k = 0; k < 3; k++) begin
            step(1, -10, 0, 0, "R4");
            step(1, 30, 0, 0, "R4");
          end
          for (int k = 0; k < 7; k++) step(1, -10, 0, 0, mode ? "R6" : "R5");
          step(1, 60, 0, 0, "R4");
          for (int k = 0; k < 7; k++) step(1, -50, 0, 0, mode ? "R6" : "R5");
          step(1, 30, 1, 0, mode ? "R6" : "R8");
          for (int k = 0; k < 7; k++) step(1, 80, 0, 0, "R5");
          step(1, 80, 1, 0, mode ? "R7" : "R8");
          for (int k = 0; k < 7; k++) step(1, 80, 0, 0, "R7");
          step(1, 80, 0, 1, "R9");
          for (int k = 0; k < 4; k++) step(1, -80, 0, 1, "R9");
          step(0, 0, 1, 1, "R9");
          step(1, -80, 0, 0, "R9");
          for (int k = 0; k < 7; k++) step(1, -80, 0, 0, "R5");
          step(1, -80, 0, 1, "R9");
          for (int k = 0; k < 3; k++) step(1, 90, 0, 1, "R9");
          step(1, 90, 0, 0, "R10");
        end
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule